// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor. Each cycle that `in_valid` is high it takes a 4-bit operation select, the accumulator operand, a memory operand, an index operand and the five incoming status flags. One clock later it presents the result, the updated flags, and two write qualifiers that tell the surrounding core whether to write the result and into which register. Fetching operands, addressing, instruction decoding and register writeback belong to the core around it.

Arithmetic runs in binary or in packed-BCD mode, selected by the incoming decimal flag. Besides the usual add, subtract, bitwise, shift, rotate, compare, increment and decrement operations, three combined operations are provided: a masked shift right, a masked load that copies its sign into carry, and a masked subtract from the index operand. Each operation has its own flag rules. The decimal flag itself always passes through unchanged.

Top module: `acc_alu`

## Requirements
- R1: Operation select codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right, 9 bit test, 10 compare, 11 increment, 12 decrement, 13 masked shift right, 14 masked sign-to-carry, 15 masked index subtract. Flags are packed as {N,V,D,Z,C} in bits 4 down to 0. In binary mode (D=0), add gives A+M+C as the result. C is the carry out, V is set when A and M have the same sign and the result's sign differs, and N/Z follow the result.
- R2: In binary mode, subtract gives A−M−(1−C). C is set when no borrow occurs, V uses the signed overflow rule for A and the complement of M, and N/Z follow the result.
- R3: With D=1 (and decimal support enabled), add and subtract treat both operands as two packed BCD digits and return the BCD sum or difference modulo 100. C is the decimal carry, or "no borrow" for subtract. N, V and Z keep their incoming values.
- R4: AND, OR and XOR of A with M set N and Z from the result and keep V and C.
- R5: Shift left moves A bit 7 into C and fills bit 0 with 0. Shift right moves A bit 0 into C and fills bit 7 with 0, so N is 0. Both set Z from the result and keep V.
- R6: Rotate left takes the old C into bit 0 and A bit 7 into C. Rotate right takes the old C into bit 7 and A bit 0 into C. N/Z follow the result and V is kept.
- R7: Bit test sets Z when A AND M is zero, copies M bit 7 into N and M bit 6 into V, and keeps C. `result` carries A and `wr_en` is 0.
- R8: Compare computes A−M in binary regardless of D. It sets C when A≥M and N/Z from the difference, and keeps V. `wr_en` is 0.
- R9: Increment and decrement apply ±1 to A with wraparound. They set only N and Z and keep V and C.
- R10: Masked shift right computes A AND M and shifts it right by one. C takes bit 0 of the masked value, N is 0 and Z follows the result. V is kept.
- R11: Masked sign-to-carry computes A AND M. N and C both take bit 7 of it, Z follows it, and V is kept.
- R12: Masked index subtract computes (A AND X)−M in binary. It sets C, N and Z like a compare and keeps V. `wr_en` and `wr_x` are both 1.
- R13: After reset, `out_valid`, `result`, `flags_out`, `wr_en` and `wr_x` are 0. An operation sampled with `in_valid` high appears one clock later with `out_valid` high. Outputs hold while `in_valid` is low, and `out_valid` then drops. The D flag is passed through unchanged by every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 4 | Operation select (R1 codes) |
| a_in | input | 8 | Accumulator operand, also the single operand of unary operations |
| m_in | input | 8 | Memory operand |
| x_in | input | 8 | Index operand for the masked index subtract |
| flags_in | input | 5 | Incoming flags {N,V,D,Z,C} |
| out_valid | output | 1 | Registered result valid |
| result | output | 8 | Registered result |
| flags_out | output | 5 | Registered updated flags {N,V,D,Z,C} |
| wr_en | output | 1 | Result is to be written back |
| wr_x | output | 1 | Write target is the index register rather than the accumulator |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid` high, because a single register stage sits between the inputs and the outputs. The bench changes inputs on the falling edge and compares all outputs on the following falling edge. This lets a new operation enter every cycle, which keeps the sweeps inside the cycle budget. For the hold rule, inputs change with `in_valid` low and the outputs are read two falling edges later, to show that nothing moved. The binary sweeps cover every accumulator value against a spread of memory values and both carry states. The decimal sweep covers every pair of valid BCD operands.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_BITS   = 4;
   localparam int FLAG_BITS = 5;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_AND    = 4'd2,
      OP_OR     = 4'd3,
      OP_XOR    = 4'd4,
      OP_SHL    = 4'd5,
      OP_SHR    = 4'd6,
      OP_ROL    = 4'd7,
      OP_ROR    = 4'd8,
      OP_TEST   = 4'd9,
      OP_CMP    = 4'd10,
      OP_INC    = 4'd11,
      OP_DEC    = 4'd12,
      OP_ANDSHR = 4'd13,
      OP_ANDSGN = 4'd14,
      OP_AXSUB  = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic v;
      logic d;
      logic z;
      logic c;
   } alu_flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
// Add/subtract core: binary ripple plus an optional per-digit BCD chain.
module acc_alu_arith #(
   parameter int W          = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         cin,
   input  logic         sub,
   input  logic         dec_mode,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   localparam int DIGITS = W / 4;

   if (W < 8 || (W % 4) != 0) begin : g_bad_width
      $error("acc_alu_arith: W must be a multiple of 4 and at least 8");
   end

   logic [W-1:0] opb_eff;
   logic [W:0]   bin_full;
   logic [W-1:0] dec_sum;
   logic         dec_cout;

   assign opb_eff  = sub ? ~opb : opb;
   assign bin_full = {1'b0, opa} + {1'b0, opb_eff} + {{W{1'b0}}, cin};
   assign ovf      = (opa[W-1] == opb_eff[W-1]) && (bin_full[W-1] != opa[W-1]);

   if (DECIMAL_EN) begin : g_decimal
      logic [DIGITS:0]  add_cy;
      logic [DIGITS:0]  sub_bw;
      logic [W-1:0]     add_res;
      logic [W-1:0]     sub_res;

      assign add_cy[0] = cin;
      assign sub_bw[0] = ~cin;

      for (genvar g = 0; g < DIGITS; g++) begin : g_digit
         logic [4:0] raw_add;
         logic [4:0] raw_sub;
         logic [4:0] adj_add;
         logic [4:0] adj_sub;
         logic       fix_add;
         logic       neg_sub;

         assign raw_add = {1'b0, opa[4*g +: 4]} + {1'b0, opb[4*g +: 4]} + {4'b0, add_cy[g]};
         assign fix_add = raw_add > 5'd9;
         assign adj_add = raw_add + 5'd6;
         assign add_res[4*g +: 4] = fix_add ? adj_add[3:0] : raw_add[3:0];
         assign add_cy[g+1] = fix_add;

         assign raw_sub = {1'b0, opa[4*g +: 4]} - {1'b0, opb[4*g +: 4]} - {4'b0, sub_bw[g]};
         assign neg_sub = raw_sub[4];
         assign adj_sub = raw_sub - 5'd6;
         assign sub_res[4*g +: 4] = neg_sub ? adj_sub[3:0] : raw_sub[3:0];
         assign sub_bw[g+1] = neg_sub;
      end

      assign dec_sum  = sub ? sub_res : add_res;
      assign dec_cout = sub ? ~sub_bw[DIGITS] : add_cy[DIGITS];
   end else begin : g_binary_only
      assign dec_sum  = bin_full[W-1:0];
      assign dec_cout = bin_full[W];
   end

   assign sum  = dec_mode ? dec_sum  : bin_full[W-1:0];
   assign cout = dec_mode ? dec_cout : bin_full[W];

endmodule

// File: rtl/acc_alu_unary.sv
// Single-operand shifter / rotator / incrementer.
module acc_alu_unary
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] opnd,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);

   always_comb begin
      res  = opnd;
      cout = cin;
      case (op)
         OP_SHL: begin res = {opnd[W-2:0], 1'b0}; cout = opnd[W-1]; end
         OP_SHR: begin res = {1'b0, opnd[W-1:1]}; cout = opnd[0];   end
         OP_ROL: begin res = {opnd[W-2:0], cin};  cout = opnd[W-1]; end
         OP_ROR: begin res = {cin, opnd[W-1:1]};  cout = opnd[0];   end
         OP_INC: res = opnd + {{(W-1){1'b0}}, 1'b1};
         OP_DEC: res = opnd - {{(W-1){1'b0}}, 1'b1};
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W          = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [OP_BITS-1:0]   op_sel,
   input  logic [W-1:0]         a_in,
   input  logic [W-1:0]         m_in,
   input  logic [W-1:0]         x_in,
   input  logic [FLAG_BITS-1:0] flags_in,
   output logic                 out_valid,
   output logic [W-1:0]         result,
   output logic [FLAG_BITS-1:0] flags_out,
   output logic                 wr_en,
   output logic                 wr_x
);

   if (W < 8 || (W % 4) != 0) begin : g_bad_width
      $error("acc_alu: W must be a multiple of 4 and at least 8");
   end

   alu_op_e    op;
   alu_flags_t fin;
   alu_flags_t fnx;
   logic [W-1:0] rnx;
   logic         we_nx;
   logic         wx_nx;
   logic         dec_mode;

   assign op       = alu_op_e'(op_sel);
   assign fin      = alu_flags_t'(flags_in);
   assign dec_mode = DECIMAL_EN && fin.d;

   logic [W-1:0] ar_sum;
   logic         ar_c;
   logic         ar_v;

   acc_alu_arith #(.W(W), .DECIMAL_EN(DECIMAL_EN)) u_arith (
      .opa      (a_in),
      .opb      (m_in),
      .cin      (fin.c),
      .sub      (op == OP_SUB),
      .dec_mode (dec_mode),
      .sum      (ar_sum),
      .cout     (ar_c),
      .ovf      (ar_v)
   );

   logic [W-1:0] un_res;
   logic         un_c;

   acc_alu_unary #(.W(W)) u_unary (
      .op   (op),
      .opnd (a_in),
      .cin  (fin.c),
      .res  (un_res),
      .cout (un_c)
   );

   // Binary compare path, shared by compare and masked index subtract
   logic [W-1:0] conj;
   logic [W-1:0] cmp_lhs;
   logic [W:0]   cmp_full;

   assign conj     = a_in & m_in;
   assign cmp_lhs  = (op == OP_AXSUB) ? (a_in & x_in) : a_in;
   assign cmp_full = {1'b0, cmp_lhs} + {1'b0, ~m_in} + {{W{1'b0}}, 1'b1};

   always_comb begin
      fnx   = fin;
      rnx   = a_in;
      we_nx = 1'b1;
      wx_nx = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin
            rnx   = ar_sum;
            fnx.c = ar_c;
            if (!dec_mode) begin
               fnx.v = ar_v;
               fnx.n = ar_sum[W-1];
               fnx.z = ~|ar_sum;
            end
         end
         OP_AND: rnx = conj;
         OP_OR:  rnx = a_in | m_in;
         OP_XOR: rnx = a_in ^ m_in;
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            rnx   = un_res;
            fnx.c = un_c;
         end
         OP_INC, OP_DEC: rnx = un_res;
         OP_TEST: begin
            we_nx = 1'b0;
            fnx.z = ~|conj;
            fnx.n = m_in[W-1];
            fnx.v = m_in[W-2];
         end
         OP_CMP: begin
            we_nx = 1'b0;
            rnx   = cmp_full[W-1:0];
            fnx.c = cmp_full[W];
         end
         OP_ANDSHR: begin
            rnx   = {1'b0, conj[W-1:1]};
            fnx.c = conj[0];
         end
         OP_ANDSGN: begin
            rnx   = conj;
            fnx.c = conj[W-1];
         end
         OP_AXSUB: begin
            wx_nx = 1'b1;
            rnx   = cmp_full[W-1:0];
            fnx.c = cmp_full[W];
         end
         default: ;
      endcase
      if (op != OP_ADD && op != OP_SUB && op != OP_TEST) begin
         fnx.n = rnx[W-1];
         fnx.z = ~|rnx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         wr_en     <= 1'b0;
         wr_x      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= rnx;
            flags_out <= fnx;
            wr_en     <= we_nx;
            wr_x      <= wx_nx;
         end
      end
   end

   // ---------------- assertions ----------------
   p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));

   p_dflag_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> flags_out[2] == $past(flags_in[2]));

   p_decimal_nvz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (DECIMAL_EN && in_valid && flags_in[2] && (op_sel == OP_ADD || op_sel == OP_SUB))
      |=> (flags_out[4] == $past(flags_in[4]) && flags_out[3] == $past(flags_in[3])
           && flags_out[1] == $past(flags_in[1])));

   p_test_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_TEST)
      |=> (!wr_en && flags_out[4] == $past(m_in[W-1]) && flags_out[3] == $past(m_in[W-2])));

   p_shr_negative_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_SHR || op_sel == OP_ANDSHR)) |=> !flags_out[4]);

   p_cmp_keeps_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_CMP) |=> (!wr_en && flags_out[3] == $past(flags_in[3])));

   p_incdec_keeps_vc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_INC || op_sel == OP_DEC))
      |=> (flags_out[3] == $past(flags_in[3]) && flags_out[0] == $past(flags_in[0])));

   p_axsub_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_AXSUB) |=> (wr_en && wr_x));

   p_sgn_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_ANDSGN) |=> flags_out[0] == flags_out[4]);

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

   localparam logic [3:0] K_ADD = 4'd0,  K_SUB = 4'd1,  K_AND = 4'd2,  K_OR  = 4'd3;
   localparam logic [3:0] K_XOR = 4'd4,  K_SHL = 4'd5,  K_SHR = 4'd6,  K_ROL = 4'd7;
   localparam logic [3:0] K_ROR = 4'd8,  K_TST = 4'd9,  K_CMP = 4'd10, K_INC = 4'd11;
   localparam logic [3:0] K_DEC = 4'd12, K_ASR = 4'd13, K_ASG = 4'd14, K_AXS = 4'd15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] a_in = '0, m_in = '0, x_in = '0;
   logic [4:0] flags_in = '0;
   logic       out_valid;
   logic [7:0] result;
   logic [4:0] flags_out;
   logic       wr_en, wr_x;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   acc_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .a_in(a_in), .m_in(m_in), .x_in(x_in), .flags_in(flags_in),
      .out_valid(out_valid), .result(result), .flags_out(flags_out),
      .wr_en(wr_en), .wr_x(wr_x)
   );

   function automatic logic [4:0] fl(input logic n, v, d, z, c);
      return {n, v, d, z, c};
   endfunction

   task automatic apply(input logic [3:0] op, input logic [7:0] a, m, x, input logic [4:0] f);
      op_sel = op; a_in = a; m_in = m; x_in = x; flags_in = f; in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [7:0] er, input logic [4:0] ef,
                             input logic ewe, input logic ewx);
      n_chk++;
      if (out_valid !== 1'b1 || result !== er || flags_out !== ef || wr_en !== ewe || wr_x !== ewx) begin
         n_fail++;
         $display("FAIL %s: got v=%b res=%h flg=%b we=%b wx=%b, expected v=1 res=%h flg=%b we=%b wx=%b",
                  req, out_valid, result, flags_out, wr_en, wr_x, er, ef, ewe, ewx);
      end
   endtask

   task automatic t_reset();
      n_chk++;
      if (out_valid !== 1'b0 || result !== 8'h00 || flags_out !== 5'b0 || wr_en !== 1'b0 || wr_x !== 1'b0) begin
         n_fail++;
         $display("FAIL R13 reset: got v=%b res=%h flg=%b we=%b wx=%b, expected all zero",
                  out_valid, result, flags_out, wr_en, wr_x);
      end
   endtask

   // R1 / R2: binary add and subtract sweep
   task automatic t_binary();
      for (int a = 0; a < 256; a++) begin
         for (int mi = 0; mi <= 37; mi++) begin
            for (int c = 0; c < 2; c++) begin
               for (int s = 0; s < 2; s++) begin
                  int m = (mi == 37) ? 255 : mi * 7;
                  int sa = (a > 127) ? a - 256 : a;
                  int sm = (m > 127) ? m - 256 : m;
                  int u, sv;
                  logic [7:0] r;
                  logic cy, ov;
                  logic [4:0] fi = fl(a[0], a[1], 1'b0, m[0], c[0]);
                  if (s == 0) begin
                     u = a + m + c; sv = sa + sm + c; cy = (u > 255);
                  end else begin
                     u = a - m - (1 - c); sv = sa - sm - (1 - c); cy = (u >= 0);
                  end
                  r  = 8'(u);
                  ov = (sv > 127) || (sv < -128);
                  apply(s ? K_SUB : K_ADD, 8'(a), 8'(m), 8'h00, fi);
                  expect_out(s ? "R2 binary subtract" : "R1 binary add",
                             r, fl(r[7], ov, 1'b0, r == 8'h00, cy), 1'b1, 1'b0);
               end
            end
         end
      end
   endtask

   // R3: decimal add and subtract over all valid BCD pairs
   task automatic t_decimal();
      for (int ad = 0; ad < 100; ad++) begin
         for (int md = 0; md < 100; md++) begin
            for (int c = 0; c < 2; c++) begin
               for (int s = 0; s < 2; s++) begin
                  int v;
                  logic cy;
                  logic [7:0] ab = 8'(((ad / 10) << 4) | (ad % 10));
                  logic [7:0] mb = 8'(((md / 10) << 4) | (md % 10));
                  logic [7:0] rb;
                  logic n0 = ad[0], v0 = md[0], z0 = ((ad + md) % 3) == 0;
                  if (s == 0) begin
                     v = ad + md + c; cy = v > 99; v = v % 100;
                  end else begin
                     v = ad - md - (1 - c); cy = v >= 0; if (v < 0) v = v + 100;
                  end
                  rb = 8'(((v / 10) << 4) | (v % 10));
                  apply(s ? K_SUB : K_ADD, ab, mb, 8'h00, fl(n0, v0, 1'b1, z0, c[0]));
                  expect_out("R3 decimal arithmetic", rb, fl(n0, v0, 1'b1, z0, cy), 1'b1, 1'b0);
               end
            end
         end
      end
   endtask

   task automatic t_logic();
      apply(K_AND, 8'hF0, 8'h0F, 8'h00, 5'b01001);
      expect_out("R4 and", 8'h00, 5'b01011, 1'b1, 1'b0);
      apply(K_OR, 8'h80, 8'h01, 8'h00, 5'b01001);
      expect_out("R4 or", 8'h81, 5'b11001, 1'b1, 1'b0);
      apply(K_XOR, 8'h5A, 8'hFF, 8'h00, 5'b00110);
      expect_out("R4 xor", 8'hA5, 5'b10100, 1'b1, 1'b0);
   endtask

   task automatic t_shift_rotate();
      logic [7:0] vals [5] = '{8'h81, 8'h40, 8'h01, 8'h00, 8'hFF};
      foreach (vals[i]) begin
         for (int c = 0; c < 2; c++) begin
            logic [7:0] v = vals[i];
            logic [7:0] r;
            logic [4:0] fi = fl(1'b0, 1'b1, 1'b0, 1'b0, c[0]);
            r = {v[6:0], 1'b0};
            apply(K_SHL, v, 8'h00, 8'h00, fi);
            expect_out("R5 shift left", r, fl(r[7], 1'b1, 1'b0, r == 0, v[7]), 1'b1, 1'b0);
            r = {1'b0, v[7:1]};
            apply(K_SHR, v, 8'h00, 8'h00, fi);
            expect_out("R5 shift right", r, fl(1'b0, 1'b1, 1'b0, r == 0, v[0]), 1'b1, 1'b0);
            r = {v[6:0], c[0]};
            apply(K_ROL, v, 8'h00, 8'h00, fi);
            expect_out("R6 rotate left", r, fl(r[7], 1'b1, 1'b0, r == 0, v[7]), 1'b1, 1'b0);
            r = {c[0], v[7:1]};
            apply(K_ROR, v, 8'h00, 8'h00, fi);
            expect_out("R6 rotate right", r, fl(r[7], 1'b1, 1'b0, r == 0, v[0]), 1'b1, 1'b0);
         end
      end
   endtask

   task automatic t_bit_test();
      apply(K_TST, 8'h0F, 8'hC0, 8'h00, 5'b00000);
      expect_out("R7 bit test zero", 8'h0F, 5'b11010, 1'b0, 1'b0);
      apply(K_TST, 8'h01, 8'h3F, 8'h00, 5'b11001);
      expect_out("R7 bit test nonzero", 8'h01, 5'b00001, 1'b0, 1'b0);
   endtask

   task automatic t_compare();
      apply(K_CMP, 8'h40, 8'h40, 8'h00, 5'b01000);
      expect_out("R8 compare equal", 8'h00, 5'b01011, 1'b0, 1'b0);
      apply(K_CMP, 8'h10, 8'h20, 8'h00, 5'b00000);
      expect_out("R8 compare less", 8'hF0, 5'b10000, 1'b0, 1'b0);
      apply(K_CMP, 8'h80, 8'h01, 8'h00, 5'b00100);
      expect_out("R8 compare decimal ignored", 8'h7F, 5'b00101, 1'b0, 1'b0);
   endtask

   task automatic t_incdec();
      apply(K_INC, 8'hFF, 8'h00, 8'h00, 5'b01001);
      expect_out("R9 increment wrap", 8'h00, 5'b01011, 1'b1, 1'b0);
      apply(K_DEC, 8'h00, 8'h00, 8'h00, 5'b00000);
      expect_out("R9 decrement wrap", 8'hFF, 5'b10000, 1'b1, 1'b0);
      apply(K_INC, 8'h7F, 8'h00, 8'h00, 5'b00001);
      expect_out("R9 increment sign", 8'h80, 5'b10001, 1'b1, 1'b0);
   endtask

   task automatic t_masked();
      apply(K_ASR, 8'hFF, 8'h03, 8'h00, 5'b10000);
      expect_out("R10 masked shift", 8'h01, 5'b00001, 1'b1, 1'b0);
      apply(K_ASR, 8'h01, 8'h01, 8'h00, 5'b01000);
      expect_out("R10 masked shift zero", 8'h00, 5'b01011, 1'b1, 1'b0);
      apply(K_ASG, 8'hF0, 8'h80, 8'h00, 5'b00000);
      expect_out("R11 sign to carry set", 8'h80, 5'b10001, 1'b1, 1'b0);
      apply(K_ASG, 8'h7F, 8'hFF, 8'h00, 5'b00001);
      expect_out("R11 sign to carry clear", 8'h7F, 5'b00000, 1'b1, 1'b0);
   endtask

   task automatic t_index_sub();
      apply(K_AXS, 8'hF3, 8'h03, 8'h3F, 5'b00000);
      expect_out("R12 index subtract", 8'h30, 5'b00001, 1'b1, 1'b1);
      apply(K_AXS, 8'h0F, 8'h10, 8'hFF, 5'b01000);
      expect_out("R12 index subtract borrow", 8'hFF, 5'b11000, 1'b1, 1'b1);
      apply(K_AXS, 8'h99, 8'h01, 8'hFF, 5'b00100);
      expect_out("R12 index subtract binary in D", 8'h98, 5'b10101, 1'b1, 1'b1);
   endtask

   task automatic t_hold();
      apply(K_OR, 8'h12, 8'h40, 8'h00, 5'b00100);
      expect_out("R13 before hold", 8'h52, 5'b00100, 1'b1, 1'b0);
      in_valid = 1'b0; op_sel = K_AXS; a_in = 8'hFF; m_in = 8'h00; x_in = 8'hFF; flags_in = 5'b11011;
      @(negedge clk);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || result !== 8'h52 || flags_out !== 5'b00100 || wr_x !== 1'b0) begin
         n_fail++;
         $display("FAIL R13 hold: got v=%b res=%h flg=%b wx=%b, expected v=0 res=52 flg=00100 wx=0",
                  out_valid, result, flags_out, wr_x);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_logic();
      t_shift_rotate();
      t_bit_test();
      t_compare();
      t_incdec();
      t_masked();
      t_index_sub();
      t_hold();
      t_binary();
      t_decimal();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule